// File: doc/BRIEF.md
# Scaler Coefficient Computation Unit

This block works out the setup word for a two-axis image scaler from a requested source size and destination size. For each axis it checks that the sizes can be handled and picks a pre-decimation step that halves the source size zero, one or two times. It then computes a fixed-point ratio with 13 fractional bits from the decimated size and the output size. The two axes are packed into a single 32-bit configuration word that the scaler datapath consumes.

A request is made by pulsing `start_i` while the unit is idle, with the four sizes presented on the same cycle. The unit handles the vertical axis (heights) first and then the horizontal axis (widths). A serial restoring divider produces one quotient bit per clock. At the end `done_o` pulses for one cycle. The result, or an error cause together with the failing axis, is held on the outputs until the next request completes.

Top module: `scc_top`

## Requirements
- R1: An axis is rejected with cause 1 when its input size is above 4096; otherwise with cause 2 when its output size is above 1024. These two checks come first, in that order.
- R2: An axis that passes R1 is rejected with cause 3 when four times its output size is less than its input size.
- R3: An axis that passes R1 and R2 is rejected with cause 4 when its output size is 0 or 1, and the divider is not started for it.
- R4: The decimation step starts at 0, with the working size equal to the input size. While the step is below 2 and the working size is above 1024 or at least twice the output size, the working size is halved (truncating) and the step goes up by one.
- R5: The coefficient is floor(8192 × (working size − 1) / (output size − 1)). A working size of 0 is treated as 1.
- R6: A coefficient of 16384 or more is replaced by 0x3FFF. The request still succeeds, and `ovf_o` is set if either axis saturated. `ovf_o` is cleared by a completion that has no saturation and by any error completion.
- R7: The word carries the vertical step in bits 31:30 and the vertical coefficient in bits 29:16. The horizontal step is in bits 15:14 and the horizontal coefficient in bits 13:0.
- R8: The vertical axis is evaluated first. `err_axis_o` is 0 for a vertical failure and 1 for a horizontal one. An error sets `err_o` and leaves `cfg_word_o` unchanged. A success clears `err_o`, the cause and `err_axis_o`.
- R9: `busy_o` rises on the clock after start is accepted. `done_o` comes 1 clock after acceptance for a vertical error, 31 clocks after for a horizontal error, and 60 clocks after for a success. `busy_o` is low in the cycle `done_o` is high.
- R10: `done_o` is high for exactly one cycle. `cfg_word_o`, `err_o`, the cause, `err_axis_o` and `ovf_o` change only on a completion.
- R11: Start is ignored while busy. Size inputs are sampled only on the accepting cycle, so changes to them during a run have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request; accepted only when idle |
| in_w_i | input | 16 | Source width |
| in_h_i | input | 16 | Source height |
| out_w_i | input | 16 | Destination width |
| out_h_i | input | 16 | Destination height |
| busy_o | output | 1 | Computation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Last request was rejected |
| err_cause_o | output | 3 | 0 none, 1 input too large, 2 output too large, 3 ratio over 4:1, 4 divide by zero |
| err_axis_o | output | 1 | Failing axis: 0 vertical, 1 horizontal |
| ovf_o | output | 1 | A coefficient was saturated |
| cfg_word_o | output | 32 | Packed scaler configuration word |

## Verification
The bench targets several boundary cases:
- sizes exactly at 4096 and 1024, where an off-by-one compare would wrongly reject a legal request;
- a ratio just beyond 4:1, which a flawed check would pass;
- an output size of 1, which would hang or produce garbage if the divider were started;
- a 3-to-2 resize that reaches exactly 16384 and must saturate;
- a 4096-to-1024 request that needs the full two halvings, so a loop that stops early would show up as a wrong step and coefficient.

Errors on each axis check the reported axis and the latency, and that the previous word survives the failed request. A restart attempt with new sizes during a run checks that neither the start nor the changed sizes leak into the result.

// File: rtl/scc_pkg.sv
package scc_pkg;
  localparam int STEP_W = 2;
  localparam int COEF_W = 14;

  typedef enum logic [2:0] {
    CAUSE_NONE    = 3'd0,
    CAUSE_IN_BIG  = 3'd1,
    CAUSE_OUT_BIG = 3'd2,
    CAUSE_RATIO   = 3'd3,
    CAUSE_DIV0    = 3'd4
  } cause_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CHECK,
    ST_DIVIDE
  } state_e;

  typedef struct packed {
    logic [STEP_W-1:0] step;
    logic [COEF_W-1:0] coef;
  } axis_cfg_t;
endpackage

// File: rtl/scc_axis_check.sv
module scc_axis_check
  import scc_pkg::*;
#(
  parameter int SIZE_W   = 16,
  parameter int IN_MAX   = 4096,
  parameter int OUT_MAX  = 1024,
  parameter int MAX_STEP = 2,
  parameter int WORK_W   = 10
) (
  input  logic [SIZE_W-1:0] in_size_i,
  input  logic [SIZE_W-1:0] out_size_i,
  output cause_e            cause_o,
  output logic [STEP_W-1:0] step_o,
  output logic [WORK_W-1:0] work_m1_o,
  output logic [WORK_W-1:0] div_m1_o
);
  localparam logic [SIZE_W-1:0] IN_LIM    = SIZE_W'(IN_MAX);
  localparam logic [SIZE_W-1:0] OUT_LIM   = SIZE_W'(OUT_MAX);
  localparam logic [SIZE_W:0]   WORK_LIM  = (SIZE_W+1)'(OUT_MAX);

  logic [SIZE_W:0]   ws;
  logic [STEP_W-1:0] st;

  // legality, in priority order
  always_comb begin
    if (in_size_i > IN_LIM)
      cause_o = CAUSE_IN_BIG;
    else if (out_size_i > OUT_LIM)
      cause_o = CAUSE_OUT_BIG;
    else if ({out_size_i, 2'b00} < {2'b00, in_size_i})
      cause_o = CAUSE_RATIO;
    else if (out_size_i <= SIZE_W'(1))
      cause_o = CAUSE_DIV0;
    else
      cause_o = CAUSE_NONE;
  end

  // bounded halving; once the condition fails it stays false
  always_comb begin
    ws = {1'b0, in_size_i};
    st = '0;
    for (int i = 0; i < MAX_STEP; i++) begin
      if ((ws > WORK_LIM) || (ws >= {out_size_i, 1'b0})) begin
        ws = ws >> 1;
        st = st + STEP_W'(1);
      end
    end
  end

  assign step_o    = st;
  assign work_m1_o = (ws == '0) ? '0 : WORK_W'(ws - (SIZE_W+1)'(1));
  assign div_m1_o  = WORK_W'(out_size_i - SIZE_W'(1));
endmodule

// File: rtl/scc_divider.sv
module scc_divider #(
  parameter int DVD_W = 28,
  parameter int DVS_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [DVD_W-1:0] dividend_i,
  input  logic [DVS_W-1:0] divisor_i,
  output logic [DVD_W-1:0] quo_o,
  output logic             vld_o
);
  localparam int CNT_W = $clog2(DVD_W + 1);

  logic [DVS_W-1:0] rem_q, rem_n, dvs_q, dvs_n;
  logic [DVD_W-1:0] quo_q, quo_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             vld_q, vld_n;
  logic [DVS_W:0]   rem_sh, diff;
  logic             ge;

  assign rem_sh = {rem_q, quo_q[DVD_W-1]};
  assign diff   = rem_sh - {1'b0, dvs_q};
  assign ge     = rem_sh >= {1'b0, dvs_q};

  always_comb begin
    rem_n = rem_q;
    quo_n = quo_q;
    cnt_n = cnt_q;
    dvs_n = dvs_q;
    vld_n = 1'b0;
    if (load_i) begin
      rem_n = '0;
      quo_n = dividend_i;
      dvs_n = divisor_i;
      cnt_n = CNT_W'(DVD_W);
    end else if (cnt_q != '0) begin
      rem_n = ge ? diff[DVS_W-1:0] : rem_sh[DVS_W-1:0];
      quo_n = {quo_q[DVD_W-2:0], ge};
      cnt_n = cnt_q - CNT_W'(1);
      vld_n = (cnt_q == CNT_W'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      dvs_q <= '0;
      cnt_q <= '0;
      vld_q <= 1'b0;
    end else begin
      rem_q <= rem_n;
      quo_q <= quo_n;
      dvs_q <= dvs_n;
      cnt_q <= cnt_n;
      vld_q <= vld_n;
    end
  end

  assign quo_o = quo_q;
  assign vld_o = vld_q;
endmodule

// File: rtl/scc_top.sv
module scc_top
  import scc_pkg::*;
#(
  parameter int SIZE_W    = 16,
  parameter int IN_MAX    = 4096,
  parameter int OUT_MAX   = 1024,
  parameter int MAX_STEP  = 2,
  parameter int FRAC_BITS = 13,
  parameter int DVD_W     = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [SIZE_W-1:0] in_w_i,
  input  logic [SIZE_W-1:0] in_h_i,
  input  logic [SIZE_W-1:0] out_w_i,
  input  logic [SIZE_W-1:0] out_h_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [2:0]        err_cause_o,
  output logic              err_axis_o,
  output logic              ovf_o,
  output logic [31:0]       cfg_word_o
);
  localparam int WORK_W = $clog2(OUT_MAX);

  state_e            state_q, state_n;
  logic              axis_q, axis_n;
  logic [SIZE_W-1:0] iw_q, ih_q, ow_q, oh_q;
  logic              accept;
  axis_cfg_t         vcfg_q, vcfg_n;
  logic              vsat_q, vsat_n;
  logic [31:0]       word_q, word_n;
  logic              err_q, err_n, eax_q, eax_n, ovf_q, ovf_n, done_q, done_n;
  cause_e            cause_q, cause_n;

  logic [SIZE_W-1:0] sel_in, sel_out;
  cause_e            chk_cause;
  logic [STEP_W-1:0] chk_step;
  logic [WORK_W-1:0] work_m1, div_m1;
  logic              div_load, div_vld, sat;
  logic [DVD_W-1:0]  quo;
  logic [COEF_W-1:0] coef;

  assign accept  = (state_q == ST_IDLE) && start_i;
  assign sel_in  = axis_q ? iw_q : ih_q;
  assign sel_out = axis_q ? ow_q : oh_q;

  scc_axis_check #(
    .SIZE_W(SIZE_W), .IN_MAX(IN_MAX), .OUT_MAX(OUT_MAX),
    .MAX_STEP(MAX_STEP), .WORK_W(WORK_W)
  ) u_chk (
    .in_size_i(sel_in), .out_size_i(sel_out), .cause_o(chk_cause),
    .step_o(chk_step), .work_m1_o(work_m1), .div_m1_o(div_m1)
  );

  assign div_load = (state_q == ST_CHECK) && (chk_cause == CAUSE_NONE);

  scc_divider #(.DVD_W(DVD_W), .DVS_W(WORK_W)) u_div (
    .clk(clk), .rst_n(rst_n), .load_i(div_load),
    .dividend_i(DVD_W'({work_m1, {FRAC_BITS{1'b0}}})),
    .divisor_i(div_m1), .quo_o(quo), .vld_o(div_vld)
  );

  assign sat  = |quo[DVD_W-1:COEF_W];
  assign coef = sat ? {COEF_W{1'b1}} : quo[COEF_W-1:0];

  always_comb begin
    state_n = state_q;
    axis_n  = axis_q;
    vcfg_n  = vcfg_q;
    vsat_n  = vsat_q;
    word_n  = word_q;
    err_n   = err_q;
    cause_n = cause_q;
    eax_n   = eax_q;
    ovf_n   = ovf_q;
    done_n  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_n = ST_CHECK;
          axis_n  = 1'b0;
        end
      end
      ST_CHECK: begin
        if (chk_cause != CAUSE_NONE) begin
          err_n   = 1'b1;
          cause_n = chk_cause;
          eax_n   = axis_q;
          ovf_n   = 1'b0;
          done_n  = 1'b1;
          state_n = ST_IDLE;
        end else begin
          state_n = ST_DIVIDE;
        end
      end
      ST_DIVIDE: begin
        if (div_vld) begin
          if (!axis_q) begin
            vcfg_n  = '{step: chk_step, coef: coef};
            vsat_n  = sat;
            axis_n  = 1'b1;
            state_n = ST_CHECK;
          end else begin
            word_n  = {vcfg_q, chk_step, coef};
            ovf_n   = vsat_q | sat;
            err_n   = 1'b0;
            cause_n = CAUSE_NONE;
            eax_n   = 1'b0;
            done_n  = 1'b1;
            state_n = ST_IDLE;
          end
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      axis_q  <= 1'b0;
      vcfg_q  <= '0;
      vsat_q  <= 1'b0;
      word_q  <= '0;
      err_q   <= 1'b0;
      cause_q <= CAUSE_NONE;
      eax_q   <= 1'b0;
      ovf_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      axis_q  <= axis_n;
      vcfg_q  <= vcfg_n;
      vsat_q  <= vsat_n;
      word_q  <= word_n;
      err_q   <= err_n;
      cause_q <= cause_n;
      eax_q   <= eax_n;
      ovf_q   <= ovf_n;
      done_q  <= done_n;
    end
  end

  // size capture, enabled only on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iw_q <= '0;
      ih_q <= '0;
      ow_q <= '0;
      oh_q <= '0;
    end else if (accept) begin
      iw_q <= in_w_i;
      ih_q <= in_h_i;
      ow_q <= out_w_i;
      oh_q <= out_h_i;
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;
  assign err_o       = err_q;
  assign err_cause_o = cause_q;
  assign err_axis_o  = eax_q;
  assign ovf_o       = ovf_q;
  assign cfg_word_o  = word_q;
endmodule

// File: rtl/scc_checker.sv
module scc_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        start_i,
  input logic        busy_o,
  input logic        done_o,
  input logic        err_o,
  input logic [2:0]  err_cause_o,
  input logic        err_axis_o,
  input logic        ovf_o,
  input logic [31:0] cfg_word_o
);
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R9
  idle_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  // R11
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i));

  // R8
  axis_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_axis_o |-> err_o);

  // R1
  cause_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (err_cause_o != 3'd0 && err_cause_o <= 3'd4));

  // R6
  sat_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |-> (cfg_word_o[29:16] == 14'h3fff || cfg_word_o[13:0] == 14'h3fff));

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(cfg_word_o) && $stable(err_o) && $stable(err_cause_o)));

  // R4
  step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_word_o[31:30] != 2'b11) && (cfg_word_o[15:14] != 2'b11));
endmodule

bind scc_top scc_checker u_scc_checker (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
  .done_o(done_o), .err_o(err_o), .err_cause_o(err_cause_o),
  .err_axis_o(err_axis_o), .ovf_o(ovf_o), .cfg_word_o(cfg_word_o)
);

// File: tb/scc_top_test.sv
module scc_top_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [15:0] in_w_i, in_h_i, out_w_i, out_h_i;
  logic        busy_o, done_o, err_o, err_axis_o, ovf_o;
  logic [2:0]  err_cause_o;
  logic [31:0] cfg_word_o;

  always #10 clk = ~clk;

  scc_top uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .in_w_i(in_w_i), .in_h_i(in_h_i), .out_w_i(out_w_i), .out_h_i(out_h_i),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .err_cause_o(err_cause_o),
    .err_axis_o(err_axis_o), .ovf_o(ovf_o), .cfg_word_o(cfg_word_o)
  );

  int    n_chk = 0, n_fail = 0;
  bit    fin = 0;
  string cur_req = "R10";

  // behavioural reference state
  bit          m_busy = 0, m_done = 0, m_err = 0, m_axis = 0, m_ovf = 0;
  int          m_cnt = 0, m_cause = 0;
  logic [31:0] m_word = 0;
  bit          p_err, p_axis, p_ovf;
  int          p_cause;
  logic [31:0] p_word;

  task automatic check_eq(string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  task automatic axis_model(input int si, input int so,
                            output int cause, output int step, output int coef, output bit sat);
    int ws;
    cause = 0; step = 0; coef = 0; sat = 0;
    if (si > 4096) cause = 1;
    else if (so > 1024) cause = 2;
    else if (so * 4 < si) cause = 3;
    else if (so <= 1) cause = 4;
    else begin
      ws = si;
      while ((ws > 1024 || ws >= 2 * so) && step < 2) begin
        ws = ws / 2;
        step++;
      end
      if (ws < 1) ws = 1;
      coef = (8192 * (ws - 1)) / (so - 1);
      if (coef >= 16384) begin coef = 16383; sat = 1; end
    end
  endtask

  task automatic model_edge();
    int vc, vs, vk, hc, hs, hk;
    bit vsat, hsat;
    if (m_busy) begin
      m_done = 0;
      m_cnt--;
      if (m_cnt == 0) begin
        m_busy = 0; m_done = 1;
        m_err = p_err; m_cause = p_cause; m_axis = p_axis; m_ovf = p_ovf;
        if (!p_err) m_word = p_word;
      end
    end else begin
      m_done = 0;
      if (start_i) begin
        m_busy = 1;
        axis_model(int'(in_h_i), int'(out_h_i), vc, vs, vk, vsat);
        if (vc != 0) begin
          m_cnt = 1; p_err = 1; p_cause = vc; p_axis = 0; p_ovf = 0;
        end else begin
          axis_model(int'(in_w_i), int'(out_w_i), hc, hs, hk, hsat);
          if (hc != 0) begin
            m_cnt = 31; p_err = 1; p_cause = hc; p_axis = 1; p_ovf = 0;
          end else begin
            m_cnt = 60; p_err = 0; p_cause = 0; p_axis = 0; p_ovf = vsat | hsat;
            p_word = (32'(vs) << 30) | (32'(vk) << 16) | (32'(hs) << 14) | 32'(hk);
          end
        end
      end
    end
  endtask

  task automatic compare();
    check_eq("busy", 32'(busy_o), 32'(m_busy));
    check_eq("done", 32'(done_o), 32'(m_done));
    check_eq("err", 32'(err_o), 32'(m_err));
    check_eq("cause", 32'(err_cause_o), 32'(m_cause));
    check_eq("axis", 32'(err_axis_o), 32'(m_axis));
    check_eq("ovf", 32'(ovf_o), 32'(m_ovf));
    check_eq("word", cfg_word_o, m_word);
  endtask

  task automatic cyc();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic run(int iw, int ih, int ow, int oh, string tag);
    cur_req = tag;
    in_w_i = 16'(iw); in_h_i = 16'(ih); out_w_i = 16'(ow); out_h_i = 16'(oh);
    start_i = 1'b1;
    cyc();
    start_i = 1'b0;
    while (m_busy) cyc();
    cyc();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired in %s", cur_req);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int lcg;
    rst_n = 1'b0; start_i = 1'b0;
    in_w_i = '0; in_h_i = '0; out_w_i = '0; out_h_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R10 reset";
    compare();
    cyc();

    run(1920, 1080, 640, 480, "R4 R5 R7 downscale");
    run(320, 240, 1024, 768, "R5 R7 upscale");
    run(4096, 4096, 1024, 1024, "R4 limits two halvings");
    run(100, 3, 100, 2, "R6 vertical saturation");
    run(3, 100, 2, 100, "R6 horizontal saturation");
    run(640, 480, 640, 480, "R6 ovf cleared by clean run");
    run(640, 5000, 320, 240, "R1 input too large vertical R8");
    run(640, 480, 2000, 240, "R1 output too large horizontal R8");
    run(4097, 480, 1025, 240, "R1 input check before output");
    run(4096, 480, 1023, 240, "R2 ratio over 4:1 horizontal");
    run(800, 401, 800, 100, "R2 ratio just over on vertical");
    run(800, 400, 800, 100, "R2 ratio exactly 4:1 legal");
    run(800, 1, 400, 1, "R3 output of one vertical");
    run(800, 0, 0, 0, "R3 output of zero vertical");
    run(1, 480, 1, 240, "R3 output of one horizontal");
    run(0, 480, 5, 240, "R5 zero input size");
    run(300, 300, 150, 150, "R4 exactly twice output");

    // R8: error keeps the previous word
    run(1280, 720, 640, 360, "R8 word before error");
    run(1280, 9000, 640, 360, "R8 error keeps word");

    // R11: start and size changes during a run are ignored
    cur_req = "R11 start while busy";
    in_w_i = 16'd1000; in_h_i = 16'd700; out_w_i = 16'd333; out_h_i = 16'd500;
    start_i = 1'b1;
    cyc();
    start_i = 1'b0;
    repeat (10) cyc();
    in_w_i = 16'd5000; in_h_i = 16'd2; out_w_i = 16'd1; out_h_i = 16'd1;
    start_i = 1'b1;
    cyc();
    cyc();
    start_i = 1'b0;
    while (m_busy) cyc();

    // R9: back-to-back start on the done cycle
    cur_req = "R9 back-to-back";
    in_w_i = 16'd720; in_h_i = 16'd576; out_w_i = 16'd360; out_h_i = 16'd288;
    start_i = 1'b1;
    cyc();
    start_i = 1'b0;
    while (m_busy) cyc();
    cyc();

    lcg = 12345;
    for (int i = 0; i < 24; i++) begin
      int iw, ih, ow, oh;
      lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
      ow = 2 + (lcg % 1023);
      lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
      oh = 2 + (lcg % 1023);
      lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
      iw = 1 + (lcg % (4 * ow < 4096 ? 4 * ow : 4096));
      lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
      ih = 1 + (lcg % (4 * oh < 4096 ? 4 * oh : 4096));
      run(iw, ih, ow, oh, "R5 R7 sweep");
    end

    fin = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule